// File: doc/BRIEF.md
# EEPROM Status Register and Write Guard

This block keeps the status byte of a serial EEPROM and decides whether a memory write or a status write may begin. The command engine decodes the serial stream and sends single-cycle strobes into this block: enable-writes, disable-writes, status write (with its data byte) and memory write (with its starting address). The block also samples the active-low write-protect pin and a timer tick. It returns the status byte for status reads, a grant pulse that tells the engine to start programming, and a busy flag. The busy flag covers the whole self-timed programming cycle.

A volatile write-enable flag must be set before any write is accepted. It is cleared by four events: the disable strobe, a low protect pin, the end of a programming cycle, and reset. Two block-protect bits select how much of the top of the array is read-only. A status write stores its new protect bits in a pending register. The old protect bits stay in force until the timed cycle ends, and the new ones take over at that moment. The cycle length is a parameter, counted in timer ticks.

Top module: `eeprom_status_guard`

## Requirements
- R1: `status_o` carries write-in-progress in bit 0, write-enable in bit 1, the protect code in bits 3:2 (bit 2 is the low bit), and reads 0 in bits 7:4. It is all zeros after reset when `BP_INIT` is 0.
- R2: An accepted status write changes only the protect code, which it takes from bits 3:2 of `wrsr_data_i`. Data bits 7:4 and 1:0 never reach the status byte.
- R3: Only `cmd_wren_i` sets the write-enable flag. A memory write or status write is granted only while that flag is 1.
- R4: The write-enable flag is cleared by `cmd_wrdi_i`, by `wp_n_i` being low in any cycle (this wins over a same-cycle enable), and by the completion of a programming cycle.
- R5: After a grant, write-in-progress and `busy_o` are 1 starting on the next cycle. They stay 1 until exactly `CYCLE_TICKS` ticks have arrived, counting from the cycle after the grant, and they clear on the clock edge that samples the last tick.
- R6: The protect code in the status byte and in the protection check keeps its old value for the whole status-write cycle. It changes only on the edge where busy falls.
- R7: While `wp_n_i` is low, no request is granted. Driving it low during a running cycle does not shorten that cycle.
- R8: `grant_o` is a combinational, single-cycle pulse. It is high only in the cycle in which an acceptable request strobe is present.
- R9: No request is granted while busy is 1.
- R10: Protect code 00 guards nothing. Code 01 guards the top quarter of the address space (0x180–0x1FF at 9 address bits). Code 10 guards the top half, and code 11 guards all addresses. A memory write whose address falls in the guarded region is refused, and the write-enable flag stays unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wp_n_i | input | 1 | Write-protect pin, active low |
| tick_i | input | 1 | Timer tick that advances the programming cycle |
| cmd_wren_i | input | 1 | Enable-writes strobe |
| cmd_wrdi_i | input | 1 | Disable-writes strobe |
| cmd_wrsr_i | input | 1 | Status-write request strobe |
| wrsr_data_i | input | 8 | Data byte of the status write |
| cmd_write_i | input | 1 | Memory-write request strobe (wins over a same-cycle status write) |
| write_addr_i | input | ADDR_W | Starting address of the memory write |
| status_o | output | 8 | Status byte |
| grant_o | output | 1 | Request accepted this cycle |
| busy_o | output | 1 | Programming cycle running |

## Verification
The bench builds the block with `ADDR_W` = 9 and `CYCLE_TICKS` = 5, and it raises the tick every other clock. With these values a whole programming cycle takes about ten clocks. Many cycles therefore fit in a short run, and there is time to inject a second request and a protect-pin drop while a cycle is still running. Nine address bits make the quarter boundary fall at 0x17F/0x180, so each protect code can be tested on both sides of its edge. The reference model compares every output on every clock.

// File: rtl/esg_pkg.sv
package esg_pkg;

  typedef enum logic [1:0] {
    PROT_NONE    = 2'b00,
    PROT_QUARTER = 2'b01,
    PROT_HALF    = 2'b10,
    PROT_ALL     = 2'b11
  } prot_e;

  localparam int STAT_WIP   = 0;
  localparam int STAT_WEL   = 1;
  localparam int STAT_PROT  = 2;

  // Assemble the status byte; upper nibble is fixed at zero.
  function automatic logic [7:0] pack_status(logic wip, logic wel, prot_e code);
    logic [7:0] s;
    s = 8'h00;
    s[STAT_WIP]            = wip;
    s[STAT_WEL]            = wel;
    s[STAT_PROT+1:STAT_PROT] = code;
    return s;
  endfunction

endpackage

// File: rtl/esg_cycle_timer.sv
module esg_cycle_timer #(
  parameter int TICKS = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic tick_i,
  output logic busy_o,
  output logic done_o
);
  localparam int CNT_W = $clog2(TICKS + 1);

  logic [CNT_W-1:0] remain_q;
  logic             busy_q;

  assign done_o = busy_q & tick_i & (remain_q == CNT_W'(1));
  assign busy_o = busy_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q   <= 1'b0;
      remain_q <= '0;
    end else if (start_i) begin
      busy_q   <= 1'b1;
      remain_q <= CNT_W'(TICKS);
    end else if (done_o) begin
      busy_q   <= 1'b0;
      remain_q <= '0;
    end else if (busy_q && tick_i) begin
      remain_q <= remain_q - CNT_W'(1);
    end
  end
endmodule

// File: rtl/esg_protect_map.sv
module esg_protect_map
  import esg_pkg::*;
#(
  parameter int ADDR_W = 9
) (
  input  prot_e             code_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              hit_o
);
  // Region membership from the two top address bits.
  function automatic logic in_region(prot_e code, logic [1:0] top);
    case (code)
      PROT_QUARTER: return top == 2'b11;
      PROT_HALF:    return top[1];
      PROT_ALL:     return 1'b1;
      default:      return 1'b0;
    endcase
  endfunction

  assign hit_o = in_region(code_i, addr_i[ADDR_W-1 -: 2]);
endmodule

// File: rtl/eeprom_status_guard.sv
module eeprom_status_guard
  import esg_pkg::*;
#(
  parameter int          ADDR_W      = 9,
  parameter int          CYCLE_TICKS = 64,
  parameter logic [1:0]  BP_INIT     = 2'b00
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wp_n_i,
  input  logic              tick_i,
  input  logic              cmd_wren_i,
  input  logic              cmd_wrdi_i,
  input  logic              cmd_wrsr_i,
  input  logic [7:0]        wrsr_data_i,
  input  logic              cmd_write_i,
  input  logic [ADDR_W-1:0] write_addr_i,
  output logic [7:0]        status_o,
  output logic              grant_o,
  output logic              busy_o
);
  logic  wel_q;
  logic  wip;
  logic  cyc_done;
  logic  addr_hit;
  logic  may_start;
  logic  write_ok;
  logic  wrsr_ok;
  logic  start_any;
  logic  wel_clear;
  logic  pend_v_q;
  prot_e prot_q;
  prot_e prot_pend_q;
  logic  unused_data;

  assign unused_data = ^{wrsr_data_i[7:4], wrsr_data_i[1:0]};

  esg_protect_map #(.ADDR_W(ADDR_W)) u_map (
    .code_i (prot_q),
    .addr_i (write_addr_i),
    .hit_o  (addr_hit)
  );

  assign may_start = wel_q & wp_n_i & ~wip;
  assign write_ok  = cmd_write_i & may_start & ~addr_hit;
  assign wrsr_ok   = cmd_wrsr_i & ~cmd_write_i & may_start;
  assign start_any = write_ok | wrsr_ok;

  esg_cycle_timer #(.TICKS(CYCLE_TICKS)) u_tmr (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (start_any),
    .tick_i  (tick_i),
    .busy_o  (wip),
    .done_o  (cyc_done)
  );

  assign wel_clear = cmd_wrdi_i | ~wp_n_i | cyc_done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          wel_q <= 1'b0;
    else if (wel_clear)  wel_q <= 1'b0;
    else if (cmd_wren_i) wel_q <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prot_q      <= prot_e'(BP_INIT);
      prot_pend_q <= PROT_NONE;
      pend_v_q    <= 1'b0;
    end else if (wrsr_ok) begin
      prot_pend_q <= prot_e'(wrsr_data_i[3:2]);
      pend_v_q    <= 1'b1;
    end else if (cyc_done && pend_v_q) begin
      prot_q   <= prot_pend_q;
      pend_v_q <= 1'b0;
    end
  end

  assign status_o = pack_status(wip, wel_q, prot_q);
  assign grant_o  = start_any;
  assign busy_o   = wip;
endmodule

// File: rtl/esg_checker.sv
module esg_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       wp_n_i,
  input logic       cmd_wren_i,
  input logic [7:0] status_o,
  input logic       grant_o,
  input logic       busy_o,
  input logic       cyc_done
);
  p_upper_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
    status_o[7:4] == 4'h0);

  p_grant_needs_wel_r3: assert property (@(posedge clk) disable iff (!rst_n)
    grant_o |-> (status_o[1] && wp_n_i));

  p_wel_set_by_wren_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status_o[1]) |-> $past(cmd_wren_i));

  p_wp_clears_wel_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !wp_n_i |=> !status_o[1]);

  p_end_clears_wel_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> !status_o[1]);

  p_grant_starts_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
    grant_o |=> busy_o);

  p_done_inside_cycle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_done |-> busy_o);

  p_prot_moves_at_end_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(status_o[3:2]) |-> $fell(busy_o));

  p_grant_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    grant_o |=> !grant_o);

  p_busy_blocks_grant_r9: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> !grant_o);
endmodule

bind eeprom_status_guard esg_checker u_esg_checker (
  .clk        (clk),
  .rst_n      (rst_n),
  .wp_n_i     (wp_n_i),
  .cmd_wren_i (cmd_wren_i),
  .status_o   (status_o),
  .grant_o    (grant_o),
  .busy_o     (busy_o),
  .cyc_done   (cyc_done)
);

// File: tb/test_eeprom_status_guard.sv
module test_eeprom_status_guard;
  localparam int AW   = 9;
  localparam int TK   = 5;
  localparam int SIZE = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wp_n = 1'b1;
  logic          tick = 1'b0;
  logic          wren = 1'b0;
  logic          wrdi = 1'b0;
  logic          wrsr = 1'b0;
  logic [7:0]    sdata = 8'h00;
  logic          wr = 1'b0;
  logic [AW-1:0] addr = '0;
  wire  [7:0]    status;
  wire           grant;
  wire           busy;

  eeprom_status_guard #(.ADDR_W(AW), .CYCLE_TICKS(TK), .BP_INIT(2'b00)) i_eeprom_status_guard (
    .clk(clk), .rst_n(rst_n), .wp_n_i(wp_n), .tick_i(tick),
    .cmd_wren_i(wren), .cmd_wrdi_i(wrdi), .cmd_wrsr_i(wrsr), .wrsr_data_i(sdata),
    .cmd_write_i(wr), .write_addr_i(addr),
    .status_o(status), .grant_o(grant), .busy_o(busy)
  );

  always #4 clk = ~clk;

  int checks = 0, fails = 0;
  bit finished = 0;
  int m_wel = 0, m_wip = 0, m_cnt = 0, m_bp = 0, m_pend = 0, m_pv = 0;
  int last_grant = 0, ticks_seen = 0;

  // Guarded if address is at or above SIZE minus the guarded fraction.
  function automatic int guarded(int bp, int a);
    int quarters;
    quarters = (bp == 3) ? 4 : bp;
    return (quarters > 0 && a >= SIZE - quarters * SIZE / 4) ? 1 : 0;
  endfunction

  function int exp_grant();
    if (!(m_wel == 1 && wp_n && m_wip == 0)) return 0;
    if (wr) return guarded(m_bp, int'(addr)) ? 0 : 1;
    return wrsr ? 1 : 0;
  endfunction

  always @(posedge clk) begin
    int g, done;
    if (!rst_n) begin
      m_wel = 0; m_wip = 0; m_cnt = 0; m_bp = 0; m_pv = 0;
    end else begin
      g    = exp_grant();
      done = (m_wip == 1 && tick && m_cnt == 1) ? 1 : 0;
      if (wrdi || !wp_n || done) m_wel = 0;
      else if (wren) m_wel = 1;
      if (done) begin
        m_wip = 0;
        if (m_pv == 1) begin m_bp = m_pend; m_pv = 0; end
      end else if (m_wip == 1 && tick) m_cnt = m_cnt - 1;
      if (g == 1) begin
        m_wip = 1; m_cnt = TK;
        if (!wr) begin m_pend = (int'(sdata) >> 2) & 3; m_pv = 1; end
      end
    end
  end

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d @%0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    chk("R1 upper bits", int'(status[7:4]), 0);
    chk("R3 write-enable", int'(status[1]), m_wel);
    chk("R5 in-progress", int'(status[0]), m_wip);
    chk("R5 busy", int'(busy), m_wip);
    chk("R6 protect code", int'(status[3:2]), m_bp);
    chk("R8 grant", int'(grant), exp_grant());
  endtask

  // Inputs are set at a falling edge; compare, then cross one rising edge.
  task automatic cyc();
    #1;
    compare_all();
    last_grant = int'(grant);
    if (busy && tick) ticks_seen++;
    @(negedge clk);
    tick = ~tick;
  endtask

  task automatic req_wren();  wren = 1; cyc(); wren = 0; endtask
  task automatic req_wrdi();  wrdi = 1; cyc(); wrdi = 0; endtask
  task automatic req_wrsr(input logic [7:0] d); wrsr = 1; sdata = d; cyc(); wrsr = 0; endtask
  task automatic req_write(input int a); wr = 1; addr = AW'(a); cyc(); wr = 0; endtask

  task automatic wait_idle();
    for (int i = 0; i < 60 && busy; i++) cyc();
  endtask

  initial begin
    @(posedge clk); @(negedge clk);
    cyc(); cyc();
    rst_n = 1;
    chk("R1 reset status", int'(status), 0);
    cyc();

    req_write(0);
    chk("R3 write refused without enable", last_grant, 0);
    req_wrsr(8'h0C);
    chk("R3 status write refused without enable", last_grant, 0);
    req_wren();
    chk("R3 enable sets flag", int'(status[1]), 1);
    req_wrdi();
    chk("R4 disable clears flag", int'(status[1]), 0);

    req_wren();
    wp_n = 0; cyc();
    chk("R4 protect pin clears flag", int'(status[1]), 0);
    req_wren();
    chk("R4 enable loses to low protect pin", int'(status[1]), 0);
    req_write(0);
    chk("R7 write refused with pin low", last_grant, 0);
    wp_n = 1; cyc();

    req_wren();
    ticks_seen = 0;
    req_write(16);
    chk("R8 write granted", last_grant, 1);
    chk("R5 busy after grant", int'(busy), 1);
    wait_idle();
    chk("R5 cycle tick count", ticks_seen, TK);
    chk("R4 flag cleared at cycle end", int'(status[1]), 0);

    req_wren();
    req_wrsr(8'hFF);
    chk("R8 status write granted", last_grant, 1);
    chk("R6 old code during cycle", int'(status[3:2]), 0);
    req_write(5);
    chk("R9 request refused while busy", last_grant, 0);
    wp_n = 0; cyc(); wp_n = 1;
    chk("R7 pin drop keeps cycle running", int'(busy), 1);
    wait_idle();
    chk("R6 new code after cycle", int'(status[3:2]), 3);
    chk("R2 data bits beyond code ignored", int'(status), 8'h0C);

    req_wren();
    req_write(0);
    chk("R10 whole array guarded", last_grant, 0);
    chk("R10 refusal keeps enable", int'(status[1]), 1);
    req_wrsr(8'hF7);
    wait_idle();
    chk("R2 quarter code stored", int'(status), 8'h04);

    req_wren();
    req_write(9'h180);
    chk("R10 quarter boundary guarded", last_grant, 0);
    req_write(9'h17F);
    chk("R10 below quarter allowed", last_grant, 1);
    wait_idle();

    req_wren();
    req_wrsr(8'h08);
    wait_idle();
    req_wren();
    req_write(9'h100);
    chk("R10 half boundary guarded", last_grant, 0);
    req_write(9'h0FF);
    chk("R10 below half allowed", last_grant, 1);
    wait_idle();

    req_wren();
    wr = 1; wrsr = 1; addr = 9'h010; sdata = 8'h00; cyc(); wr = 0; wrsr = 0;
    wait_idle();
    chk("R6 memory write leaves code alone", int'(status[3:2]), 2);
    cyc(); cyc();

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule